// File: doc/BRIEF.md
# DMA Write Completion Handshake

This block decides when a DMA write transfer for one channel or endpoint may be reported as complete when the data lands in remote system memory. It watches a pulse for each write transaction that finishes at the core boundary. For each pulse it also sees a flag that marks the final transaction and the channel number. Two configuration bits set its behaviour. With the remote-memory option off, the transfer-complete interrupt pulses as soon as the final write leaves the core, and the system is never asked anything.

With the remote-memory option on, the block raises a request to the system and waits for the system's done input before it continues. A one-cycle internal-done pulse marks the start of each request. A last-flag sideband and a channel-number sideband travel with the request. The notify-each bit decides whether every write transaction is handshaked or only the final one. While a request is outstanding, the block refuses new write transactions, and it signals this on a ready output. Transfer-complete for a remote write fires only after the system acknowledges the final transaction.

Top module: `dma_wr_ack_gate`

## Requirements
- R1: After reset, `ext_req`, `int_done` and `xfer_cmpl` are low and `wr_ready` is high.
- R2: With `cfg_remote_en` low, an accepted `wr_done` with `wr_last` high produces a one-cycle `xfer_cmpl` in the next cycle. `ext_req` and `int_done` stay low, and a non-final write produces no output.
- R3: With `cfg_remote_en` and `cfg_notify_each` high, every accepted `wr_done` raises `ext_req` in the next cycle. `ext_req` stays high for as long as `sys_ack` is low.
- R4: `int_done` is high for exactly the first cycle of each `ext_req` assertion and is low at all other times.
- R5: On a notifying write, `sb_last` and `sb_chan` take the values of `wr_last` and `wr_chan`. They do not change while `ext_req` is high.
- R6: With `cfg_remote_en` high and `cfg_notify_each` low, a non-final write raises neither `ext_req` nor `xfer_cmpl`. A final write raises `ext_req`.
- R7: `sys_ack` sampled high while `ext_req` is high produces a one-cycle `xfer_cmpl` in the next cycle only if the captured `sb_last` is 1.
- R8: `ext_req` falls in the cycle after `sys_ack` is sampled high while it is high.
- R9: While `ext_req` is high, `wr_ready` is low and `wr_done` is ignored. This includes the cycle in which `sys_ack` arrives.
- R10: `sys_ack` while no request is outstanding has no effect.
- R11: `cfg_notify_each` has no effect while `cfg_remote_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_remote_en | input | 1 | Wait for system acknowledge on DMA writes |
| cfg_notify_each | input | 1 | Handshake every write, not only the final one |
| wr_done | input | 1 | One write transaction finished at the core boundary |
| wr_last | input | 1 | That transaction is the final one of the transfer |
| wr_chan | input | CH_W | Channel/endpoint of that transaction |
| sys_ack | input | 1 | System-side done for the outstanding request |
| wr_ready | output | 1 | High when a new write transaction may be accepted |
| ext_req | output | 1 | Request to the system, held until acknowledged |
| int_done | output | 1 | One-cycle pulse: core writes finished, request starts |
| sb_last | output | 1 | Final-transaction flag of the outstanding request |
| sb_chan | output | CH_W | Channel number of the outstanding request |
| xfer_cmpl | output | 1 | One-cycle transfer-complete interrupt pulse |

## Verification
Two events can collide: the system acknowledge that ends a request, and a new write-done pulse that arrives in the same cycle. The bench provokes this by driving `sys_ack` and `wr_done` together, using a different channel number. The design is correct if the request drops with completion reported for the old transaction, the sideband keeps the old channel, and no new request starts in the following cycles. A second case checks an acknowledge that arrives while no request is outstanding: it must leave all outputs quiet.

// File: rtl/dma_wr_ack_gate.sv
module dma_wr_ack_gate #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_remote_en,
  input  logic            cfg_notify_each,
  input  logic            wr_done,
  input  logic            wr_last,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            sys_ack,
  output logic            wr_ready,
  output logic            ext_req,
  output logic            int_done,
  output logic            sb_last,
  output logic [CH_W-1:0] sb_chan,
  output logic            xfer_cmpl
);

  logic            req_q;
  logic            start_q;
  logic            cmpl_q;
  logic            last_q;
  logic [CH_W-1:0] chan_q;

  wire take      = wr_done && !req_q;
  wire notify    = take && cfg_remote_en && (cfg_notify_each || wr_last);
  wire local_end = take && !cfg_remote_en && wr_last;
  wire ack_hit   = req_q && sys_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      start_q <= 1'b0;
      cmpl_q  <= 1'b0;
      last_q  <= 1'b0;
      chan_q  <= '0;
    end else begin
      start_q <= notify;
      cmpl_q  <= local_end || (ack_hit && last_q);
      if (notify) begin
        req_q  <= 1'b1;
        last_q <= wr_last;
        chan_q <= wr_chan;
      end else if (ack_hit) begin
        req_q <= 1'b0;
      end
    end
  end

  assign wr_ready  = !req_q;
  assign ext_req   = req_q;
  assign int_done  = start_q;
  assign sb_last   = last_q;
  assign sb_chan   = chan_q;
  assign xfer_cmpl = cmpl_q;

endmodule

// File: rtl/dma_wr_ack_gate_chk.sv
module dma_wr_ack_gate_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_remote_en,
  input logic            wr_done,
  input logic            sys_ack,
  input logic            wr_ready,
  input logic            ext_req,
  input logic            int_done,
  input logic            sb_last,
  input logic [CH_W-1:0] sb_chan,
  input logic            xfer_cmpl
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !sys_ack |=> ext_req);

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && sys_ack |=> !ext_req);

  // R4
  done_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |-> ext_req);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |=> !int_done);

  // R5
  sb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |=> $stable(sb_chan) && $stable(sb_last));

  // R2
  local_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_remote_en && wr_ready && wr_done |=> !ext_req && !int_done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready && wr_done |=> !int_done);

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready && !wr_done && sys_ack |=> !ext_req && !xfer_cmpl);

  // R7
  cmpl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cmpl |=> !xfer_cmpl);

endmodule

bind dma_wr_ack_gate dma_wr_ack_gate_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_remote_en(cfg_remote_en), .wr_done(wr_done),
  .sys_ack(sys_ack), .wr_ready(wr_ready), .ext_req(ext_req), .int_done(int_done),
  .sb_last(sb_last), .sb_chan(sb_chan), .xfer_cmpl(xfer_cmpl)
);

// File: tb/dma_wr_ack_gate_tb.sv
module dma_wr_ack_gate_tb;
  localparam int CH_W = 4;
  localparam int NV = 8;
  // {remote, each, last, chan[3:0], exp_req, exp_cmpl}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_1_0011_0_1,
    9'b0_1_0_0101_0_0,
    9'b0_1_1_1001_0_1,
    9'b1_1_0_0110_1_0,
    9'b1_1_1_1010_1_1,
    9'b1_0_0_0111_0_0,
    9'b1_0_1_1100_1_1,
    9'b1_1_0_1111_1_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_remote_en = 1'b0, cfg_notify_each = 1'b0;
  logic wr_done = 1'b0, wr_last = 1'b0, sys_ack = 1'b0;
  logic [CH_W-1:0] wr_chan = '0;
  logic wr_ready, ext_req, int_done, sb_last, xfer_cmpl;
  logic [CH_W-1:0] sb_chan;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_wr_ack_gate #(.CH_W(CH_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_remote_en(cfg_remote_en),
    .cfg_notify_each(cfg_notify_each), .wr_done(wr_done), .wr_last(wr_last),
    .wr_chan(wr_chan), .sys_ack(sys_ack), .wr_ready(wr_ready), .ext_req(ext_req),
    .int_done(int_done), .sb_last(sb_last), .sb_chan(sb_chan), .xfer_cmpl(xfer_cmpl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 req", int'(ext_req), 0);
    chk("R1 done", int'(int_done), 0);
    chk("R1 cmpl", int'(xfer_cmpl), 0);
    chk("R1 ready", int'(wr_ready), 1);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      cfg_remote_en = v[8]; cfg_notify_each = v[7];
      wr_last = v[6]; wr_chan = v[5:2];
      wr_done = 1'b1;
      step();
      wr_done = 1'b0;
      chk("R3/R6 req", int'(ext_req), int'(v[1]));
      chk("R4 done", int'(int_done), int'(v[1]));
      chk("R2/R11 cmpl", int'(xfer_cmpl), int'(!v[8] && v[0]));
      if (v[1]) begin
        chk("R5 chan", int'(sb_chan), int'(v[5:2]));
        chk("R5 last", int'(sb_last), int'(v[6]));
        chk("R9 ready", int'(wr_ready), 0);
        step();
        chk("R4 done low", int'(int_done), 0);
        chk("R3 hold", int'(ext_req), 1);
        wr_done = 1'b1; wr_chan = ~v[5:2]; wr_last = ~v[6];
        step();
        wr_done = 1'b0;
        chk("R9 chan kept", int'(sb_chan), int'(v[5:2]));
        chk("R3 hold2", int'(ext_req), 1);
        chk("R7 no early cmpl", int'(xfer_cmpl), 0);
        sys_ack = 1'b1;
        step();
        sys_ack = 1'b0;
        chk("R8 drop", int'(ext_req), 0);
        chk("R7 cmpl", int'(xfer_cmpl), int'(v[0]));
      end else begin
        step();
        chk("R2/R6 quiet req", int'(ext_req), 0);
      end
      step();
      chk("R7 cmpl single", int'(xfer_cmpl), 0);
    end

    // R10: idle acknowledge
    cfg_remote_en = 1'b1; cfg_notify_each = 1'b1;
    sys_ack = 1'b1;
    step();
    sys_ack = 1'b0;
    chk("R10 req", int'(ext_req), 0);
    chk("R10 cmpl", int'(xfer_cmpl), 0);

    // R9: acknowledge and new write in the same cycle
    wr_done = 1'b1; wr_last = 1'b1; wr_chan = 4'd2;
    step();
    wr_done = 1'b0;
    chk("R3 req", int'(ext_req), 1);
    wr_done = 1'b1; wr_last = 1'b0; wr_chan = 4'd13; sys_ack = 1'b1;
    step();
    wr_done = 1'b0; sys_ack = 1'b0;
    chk("R9 collide req", int'(ext_req), 0);
    chk("R9 collide chan", int'(sb_chan), 2);
    chk("R7 collide cmpl", int'(xfer_cmpl), 1);
    step();
    chk("R9 no restart", int'(ext_req), 0);
    chk("R9 no done", int'(int_done), 0);
    chk("R9 ready", int'(wr_ready), 1);

    // R1: reset while busy
    wr_done = 1'b1; wr_last = 1'b0;
    step();
    wr_done = 1'b0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R1 reset req", int'(ext_req), 0);
    chk("R1 reset ready", int'(wr_ready), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule